// File: doc/BRIEF.md
# Request Acceptance Port with Blocking Causes and Deferred Retry

This block sits at the upstream edge of a memory-side agent and decides, cycle by cycle, whether an incoming request is taken. Eight independent blocking causes can be raised and dropped through per-bit set and clear strobes. While any cause is raised, the port is blocked and refuses requests. A refused requester is owed a retry: the port keeps refusing until that retry has been delivered, so a requester that was turned away cannot be overtaken by a later one.

When the last raised cause drops and a retry is owed, the port arms a retry. If no cause is raised again in the following cycle, a one-cycle retry pulse goes out in the cycle after that, and the port is ready in the same cycle. A cause raised during the armed cycle cancels the retry. The retry is then re-armed when the port next becomes unblocked. The tag lookup, response queuing and snoop handling behind the port are not part of this block.

Top module: `req_retry_port`

## Requirements
- R1: After a synchronous active-low reset, the cause vector is all zero, `blocked` is 0, `req_ready` is 1, `retry_pulse` is 0, and no retry is owed or armed, whatever state existed before the reset.
- R2: `blocked` is 1 in exactly those cycles in which at least one bit of `cause_vec` is 1.
- R3: Bit i of `cause_vec` becomes 1 in the cycle after `cause_set[i]` is 1. It becomes 0 after `cause_clr[i]` alone is 1. It holds its value otherwise. Set wins over clear on the same bit. Setting a bit that is already set, or clearing a bit that is already clear, leaves every other bit unchanged.
- R4: A request (`req_valid`=1) in a cycle where the port is blocked or a retry is owed sees `req_ready`=0 and `req_accept`=0. From the next cycle on, a retry is owed.
- R5: A request in a cycle where the port is not blocked and no retry is owed sees `req_ready`=1 and `req_accept`=1, and no retry becomes owed.
- R6: Suppose the last raised cause is cleared in cycle T while a retry is owed. If no set strobe arrives in T+1, then `retry_pulse` is 1 in T+2 for exactly one cycle. A request in T+1 is still refused.
- R7: A set strobe in cycle T+1 cancels the armed retry. `retry_pulse` stays 0 and the retry remains owed until the port next becomes unblocked.
- R8: When the last cause clears and no retry is owed, no retry pulse is produced.
- R9: In the cycle `retry_pulse` is 1, the owed retry is cleared and `req_ready` is 1, so a request in that cycle is accepted.
- R10: A request refused in the same cycle that the last cause is cleared makes the retry owed in time for that clear. The pulse follows at T+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cause_set | input | 8 | Per-cause raise strobes |
| cause_clr | input | 8 | Per-cause drop strobes |
| req_valid | input | 1 | Upstream request present |
| req_ready | output | 1 | Port would take a request this cycle |
| req_accept | output | 1 | Request taken this cycle |
| retry_pulse | output | 1 | One-cycle retry indication to the requester |
| blocked | output | 1 | At least one cause raised |
| cause_vec | output | 8 | Current blocking-cause bits |

## Verification
The assertions assume that strobes and `req_valid` are known (not X) and stable around the clock edge. They also assume that a requester keeps presenting or re-presents requests without regard to the retry. The checks do not depend on the requester withdrawing after a refusal. The bench drives every input only at the falling edge, from a table and from short directed sequences. It holds all strobes at zero during reset, so every property starts from the reset state. Overlapping set and clear on one bit, and requests in the clear cycle and in the armed cycle, are driven on purpose, because they are the orderings the retry logic must resolve.

// File: rtl/req_retry_pkg.sv
// Package: shared widths and types for the request/retry port.
// Assumes: one bit per blocking cause, at most a few dozen causes.
package req_retry_pkg;
    localparam int unsigned CAUSE_W = 8;
    typedef logic [CAUSE_W-1:0] cause_vec_t;

    // Retry tracker state, kept as a struct for readability.
    typedef struct packed {
        logic owed;   // a refused requester is still owed a retry
        logic armed;  // last cause dropped; retry goes out next cycle
        logic fire;   // retry pulse this cycle
    } retry_state_t;
endpackage

// File: rtl/cause_bits.sv
// Module: cause_bits
// Holds the blocking-cause vector, one flop per cause with its own
// set/clear strobe (set wins). Also reports the next-cycle vector and a
// "last cause drops" flag for the retry tracker.
// Assumes: strobes are single-cycle, active-high, synchronous to clk.
module cause_bits #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] cause_o,
    output logic         any_o,
    output logic         last_drop_o,
    output logic         any_set_o
);
    logic [W-1:0] cause_q;
    logic [W-1:0] cause_d;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Next value of bit i: set wins, otherwise clear, otherwise hold.
        always_comb begin
            if (set_i[i])      cause_d[i] = 1'b1;
            else if (clr_i[i]) cause_d[i] = 1'b0;
            else               cause_d[i] = cause_q[i];
        end

        // Register bit i with synchronous reset.
        always_ff @(posedge clk) begin
            if (!rst_n) cause_q[i] <= 1'b0;
            else        cause_q[i] <= cause_d[i];
        end

        // R3: a set strobe always lands, even with a clear on the same bit.
        a_r3_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> cause_q[i]);
        // R3: a lone clear strobe drops the bit.
        a_r3_clr_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !cause_q[i]);
        // R3: without a strobe on this bit it holds.
        a_r3_bit_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i[i] && !set_i[i]) |=> $stable(cause_q[i]));
    end

    // Summary flags for the tracker.
    always_comb begin
        any_o       = |cause_q;
        any_set_o   = |set_i;
        last_drop_o = (|cause_q) && !(|cause_d);
    end

    assign cause_o = cause_q;
endmodule

// File: rtl/retry_tracker.sv
// Module: retry_tracker
// Decides acceptance and tracks the owed retry. A refusal makes a retry
// owed. When the last cause drops while owed, the retry is armed. If no
// cause is raised in the armed cycle, the pulse fires next cycle and the
// debt clears. A raise in the armed cycle cancels the arm.
// Assumes: blocked_i reflects registered cause state, any_set_i the
// strobes of the current cycle.
module retry_tracker
    import req_retry_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid_i,
    input  logic blocked_i,
    input  logic last_drop_i,
    input  logic any_set_i,
    output logic ready_o,
    output logic accept_o,
    output logic retry_o
);
    retry_state_t st_q;
    retry_state_t st_d;
    logic refuse;
    logic fire_now;

    // Acceptance: take a request only with no cause and no debt.
    always_comb begin
        ready_o  = !blocked_i && !st_q.owed;
        accept_o = req_valid_i && ready_o;
        refuse   = req_valid_i && !ready_o;
    end

    // Next state: arm on last drop with a debt, fire unless re-raised.
    always_comb begin
        fire_now   = st_q.armed && !any_set_i;
        st_d.armed = last_drop_i && (st_q.owed || refuse);
        st_d.fire  = fire_now;
        if (fire_now)      st_d.owed = 1'b0;
        else if (refuse)   st_d.owed = 1'b1;
        else if (accept_o) st_d.owed = 1'b0;
        else               st_d.owed = st_q.owed;
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign retry_o = st_q.fire;

    // R6: the retry pulse lasts one cycle.
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        retry_o |=> !retry_o);
    // R6: an armed retry without a new raise fires next cycle.
    a_r6_armed_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && !any_set_i) |=> retry_o);
    // R7: a raise during the armed cycle cancels the pulse.
    a_r7_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && any_set_i) |=> !retry_o);
    // R9: the port is ready in the retry cycle.
    a_r9_ready_on_retry: assert property (@(posedge clk) disable iff (!rst_n)
        retry_o |-> ready_o);
    // R4: a refusal leaves the port unready next cycle unless the retry fires.
    a_r4_refuse_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !ready_o) |=> (!ready_o || retry_o));
endmodule

// File: rtl/req_retry_port.sv
// Module: req_retry_port (top)
// Upstream request acceptance with independent blocking causes and a
// deferred one-cycle retry to requesters that were refused.
// Assumes: synchronous active-low reset; all inputs synchronous to clk.
module req_retry_port
    import req_retry_pkg::*;
#(
    parameter int unsigned N_CAUSE = CAUSE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CAUSE-1:0] cause_set,
    input  logic [N_CAUSE-1:0] cause_clr,
    input  logic               req_valid,
    output logic               req_ready,
    output logic               req_accept,
    output logic               retry_pulse,
    output logic               blocked,
    output logic [N_CAUSE-1:0] cause_vec
);
    logic any_cause;
    logic last_drop;
    logic any_set;

    cause_bits #(.W(N_CAUSE)) u_causes (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (cause_set),
        .clr_i       (cause_clr),
        .cause_o     (cause_vec),
        .any_o       (any_cause),
        .last_drop_o (last_drop),
        .any_set_o   (any_set)
    );

    retry_tracker u_retry (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .blocked_i   (any_cause),
        .last_drop_i (last_drop),
        .any_set_i   (any_set),
        .ready_o     (req_ready),
        .accept_o    (req_accept),
        .retry_o     (retry_pulse)
    );

    assign blocked = any_cause;

    // R2: a blocked port never takes a request.
    a_r2_blocked_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |-> !req_accept);
    // R6: a retry only follows a cycle in which the port was unblocked.
    a_r6_retry_after_unblock: assert property (@(posedge clk) disable iff (!rst_n)
        retry_pulse |-> $past(!blocked));
    // R5: an accepted request causes no retry in the next cycle.
    a_r5_accept_no_debt: assert property (@(posedge clk) disable iff (!rst_n)
        req_accept |=> !retry_pulse);
endmodule

// File: tb/req_retry_port_bench.sv
module req_retry_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cause_set = '0;
    logic [7:0] cause_clr = '0;
    logic       req_valid = 1'b0;
    logic       req_ready, req_accept, retry_pulse, blocked;
    logic [7:0] cause_vec;
    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;  // 125 MHz

    req_retry_port u_req_retry_port (
        .clk(clk), .rst_n(rst_n), .cause_set(cause_set), .cause_clr(cause_clr),
        .req_valid(req_valid), .req_ready(req_ready), .req_accept(req_accept),
        .retry_pulse(retry_pulse), .blocked(blocked), .cause_vec(cause_vec)
    );

    // Row: set[27:20] clr[19:12] valid[11] exp_cause[10:3] ready[2] acc[1] retry[0]
    localparam int NROW = 27;
    localparam logic [27:0] TBL [NROW] = '{
        {8'h00, 8'h00, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0},
        {8'h01, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},
        {8'h00, 8'h00, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0},
        {8'h04, 8'h00, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0},
        {8'h04, 8'h00, 1'b0, 8'h05, 1'b0, 1'b0, 1'b0},
        {8'h00, 8'h01, 1'b0, 8'h05, 1'b0, 1'b0, 1'b0},
        {8'h00, 8'h01, 1'b0, 8'h04, 1'b0, 1'b0, 1'b0},
        {8'h00, 8'h04, 1'b0, 8'h04, 1'b0, 1'b0, 1'b0},
        {8'h00, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0},
        {8'h00, 8'h00, 1'b1, 8'h00, 1'b1, 1'b1, 1'b1},
        {8'h00, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},
        {8'h02, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},
        {8'h00, 8'h00, 1'b1, 8'h02, 1'b0, 1'b0, 1'b0},
        {8'h00, 8'h02, 1'b0, 8'h02, 1'b0, 1'b0, 1'b0},
        {8'h08, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        {8'h00, 8'h00, 1'b0, 8'h08, 1'b0, 1'b0, 1'b0},
        {8'h00, 8'h08, 1'b0, 8'h08, 1'b0, 1'b0, 1'b0},
        {8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        {8'h00, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1},
        {8'h10, 8'h10, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},
        {8'h00, 8'h10, 1'b1, 8'h10, 1'b0, 1'b0, 1'b0},
        {8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        {8'h00, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1},
        {8'h20, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},
        {8'h00, 8'h20, 1'b0, 8'h20, 1'b0, 1'b0, 1'b0},
        {8'h00, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},
        {8'h00, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    // Drive at the falling edge, settle, leave sampling to the caller.
    task automatic drive(input logic [7:0] s, input logic [7:0] c, input logic v);
        @(negedge clk);
        cause_set = s; cause_clr = c; req_valid = v;
        #2;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: state right out of reset.
        check("R1 cause", cause_vec, 8'h00);
        check("R1 ready", {7'd0, req_ready}, 8'd1);
        check("R1 retry", {7'd0, retry_pulse}, 8'd0);

        for (int k = 0; k < NROW; k++) begin
            drive(TBL[k][27:20], TBL[k][19:12], TBL[k][11]);
            check("R3 cause", cause_vec, TBL[k][10:3]);
            check("R2 blocked", {7'd0, blocked}, {7'd0, |TBL[k][10:3]});
            check("R4 ready", {7'd0, req_ready}, {7'd0, TBL[k][2]});
            check("R5 accept", {7'd0, req_accept}, {7'd0, TBL[k][1]});
            check("R6 retry", {7'd0, retry_pulse}, {7'd0, TBL[k][0]});
        end

        // R10: refusal in the very cycle the last cause clears.
        drive(8'h01, 8'h00, 1'b0);
        drive(8'h00, 8'h01, 1'b1);
        check("R10 refused", {7'd0, req_accept}, 8'd0);
        drive(8'h00, 8'h00, 1'b0);
        check("R10 armed no pulse", {7'd0, retry_pulse}, 8'd0);
        drive(8'h00, 8'h00, 1'b0);
        check("R10 pulse", {7'd0, retry_pulse}, 8'd1);

        // R7: raise in the armed cycle cancels; retry owed until next unblock.
        drive(8'h02, 8'h00, 1'b0);
        drive(8'h00, 8'h00, 1'b1);
        drive(8'h00, 8'h02, 1'b0);
        drive(8'h40, 8'h00, 1'b1);
        check("R7 armed cycle refuses", {7'd0, req_ready}, 8'd0);
        drive(8'h00, 8'h00, 1'b0);
        check("R7 cancelled", {7'd0, retry_pulse}, 8'd0);
        check("R7 reblocked", cause_vec, 8'h40);
        drive(8'h00, 8'h40, 1'b0);
        drive(8'h00, 8'h00, 1'b0);
        check("R7 still owed", {7'd0, req_ready}, 8'd0);
        drive(8'h00, 8'h00, 1'b1);
        // R9: retry cycle is ready and takes the request.
        check("R9 pulse", {7'd0, retry_pulse}, 8'd1);
        check("R9 accept", {7'd0, req_accept}, 8'd1);
        drive(8'h00, 8'h00, 1'b0);
        check("R9 single pulse", {7'd0, retry_pulse}, 8'd0);

        // R8: unblocking with no debt gives no pulse.
        drive(8'h80, 8'h00, 1'b0);
        drive(8'h00, 8'h80, 1'b0);
        drive(8'h00, 8'h00, 1'b0);
        check("R8 no pulse a", {7'd0, retry_pulse}, 8'd0);
        drive(8'h00, 8'h00, 1'b0);
        check("R8 no pulse b", {7'd0, retry_pulse}, 8'd0);

        // R1: reset in the middle of a blocked, owed state.
        drive(8'h0F, 8'h00, 1'b0);
        drive(8'h00, 8'h00, 1'b1);
        drive(8'h00, 8'h00, 1'b0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #2;
        check("R1 cause cleared", cause_vec, 8'h00);
        check("R1 blocked low", {7'd0, blocked}, 8'd0);
        check("R1 ready", {7'd0, req_ready}, 8'd1);
        drive(8'h00, 8'h00, 1'b0);
        check("R1 no stale retry a", {7'd0, retry_pulse}, 8'd0);
        drive(8'h00, 8'h00, 1'b0);
        check("R1 no stale retry b", {7'd0, retry_pulse}, 8'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule